// File: doc/BRIEF.md
# Pretrigger Capture Buffer Controller

This block records a vector of probed signals from a design under test into an on-chip circular memory. Once armed, it writes a sample on every clock and keeps a sliding window of recent history. A selectable start event then marks the trigger sample. Recording continues until a selectable stop event. The host can then drain the kept samples, oldest first, through a simple request/response read port. Status outputs show the sequencer state, how many samples are held and where the trigger sample sits in that sequence.

The same block gates the design under test. A registered clock enable lets the host run the design continuously or advance it one cycle at a time. A registered reset request lets the host reset it without touching the capture logic. A live-monitor path copies the probe vector into a host-visible register on every cycle while it is enabled. That path does not use the memory and is only meaningful for slow or stepped execution.

The sequencer has four states:
- IDLE (code 0).
- ARMED (code 1): pretrigger filling.
- RECORDING (code 2).
- DONE (code 3).

It has these transitions:
- arm: IDLE or DONE to ARMED.
- start: ARMED to RECORDING.
- start-and-stop: ARMED straight to DONE, when the trigger sample already meets the stop rule.
- stop: RECORDING to DONE.

Top module: `trace_capture`

## Requirements
- R1: After reset the state is IDLE (code 0), the held-sample count and trigger position are 0, `rd_valid_o` is 0, `dut_clk_en_o` is 0 and `dut_rst_o` is 1. The state encoding is IDLE=0, ARMED=1, RECORDING=2, DONE=3.
- R2: A high `arm_i` in IDLE or DONE moves the block to ARMED, clears the held-sample count and the trigger position, and restarts writing at address 0. A high `arm_i` in ARMED or RECORDING has no effect.
- R3: In ARMED, one probe sample is written per clock and the held count saturates at min(`pre_len_i`, DEPTH-1). If the start event comes earlier, only the samples actually written since arming are held.
- R4: `start_sel_i` picks the start source: 0 or 3 selects `trig_start_i`, 1 selects `dut_start_i`, 2 selects `manual_start_i`. Unselected sources are ignored. The sample written in the start cycle is the trigger sample, and `trig_pos_o` becomes the number of pretrigger samples held before it.
- R5: `stop_sel_i` picks the stop source: 0 selects `trig_stop_i`, 1 selects the timer, 2 or 3 select memory-full only. The timer ends recording once `timer_len_i` post-trigger samples (including the trigger sample; a value of 0 acts as 1) have been written. The stop rule is also applied to the trigger sample itself, and unselected stop sources are ignored.
- R6: Whatever the stop selection, recording ends in the cycle that the held count reaches DEPTH.
- R7: DONE holds, with the held count and trigger position frozen, until `arm_i`.
- R8: In DONE, each cycle with `rd_req_i` high while samples remain returns the next sample on `rd_data_o` with `rd_valid_o` high one cycle later. Samples come oldest first and wrap around the memory. Once all samples are returned, requests give no `rd_valid_o`.
- R9: `dut_clk_en_o` is high in the cycle after a clock in which `dut_run_i` or `dut_step_i` is high, and low otherwise. A one-cycle step pulse gives exactly one enabled cycle.
- R10: `dut_rst_o` follows `dut_rst_req_i` with one cycle of delay.
- R11: While `mon_en_i` is high, `mon_data_o` takes the probe value sampled at each clock. While it is low, `mon_data_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of the capture logic |
| probe_i | input | DATA_W | Probed signal vector |
| arm_i | input | 1 | Arm request |
| start_sel_i | input | 2 | Start source select |
| stop_sel_i | input | 2 | Stop source select |
| trig_start_i | input | 1 | Start trigger pulse |
| dut_start_i | input | 1 | Design-under-test start indication |
| manual_start_i | input | 1 | Host start command |
| trig_stop_i | input | 1 | Stop trigger pulse |
| pre_len_i | input | $clog2(DEPTH)+1 | Pretrigger length in cycles |
| timer_len_i | input | TIMER_W | Post-trigger length in cycles |
| rd_req_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Read sample |
| rd_valid_o | output | 1 | Read sample valid |
| state_o | output | 2 | Sequencer state |
| valid_cnt_o | output | $clog2(DEPTH)+1 | Held sample count |
| trig_pos_o | output | $clog2(DEPTH)+1 | Index of trigger sample in readout order |
| mon_en_i | input | 1 | Live monitor enable |
| mon_data_o | output | DATA_W | Live monitor sample |
| dut_run_i | input | 1 | Run design continuously |
| dut_step_i | input | 1 | Single-step pulse |
| dut_rst_req_i | input | 1 | Host reset request for design |
| dut_clk_en_o | output | 1 | Design clock enable |
| dut_rst_o | output | 1 | Design reset |

## Verification
The start event and a stop event can land on the same clock. Either the stop trigger is pulsed together with the start trigger, or the pretrigger window is already full when the start arrives, so the trigger sample fills the memory. The bench provokes both cases. For the first it expects DONE with exactly one held sample at trigger position 0. For the second it expects DONE with DEPTH samples and trigger position DEPTH-1, with the drained data matching the probe values of the matching cycles. A further case checks that a stop pulse arriving during RECORDING under timer selection does not end the run early.

// File: rtl/trace_cap_pkg.sv
package trace_cap_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE   = 2'd0,
        CAP_ARMED  = 2'd1,
        CAP_RECORD = 2'd2,
        CAP_DONE   = 2'd3
    } cap_state_e;

    typedef enum logic [1:0] {
        SRC_TRIG     = 2'd0,
        SRC_DUT      = 2'd1,
        SRC_MANUAL   = 2'd2,
        SRC_TRIG_ALT = 2'd3
    } start_src_e;

    typedef enum logic [1:0] {
        END_TRIG     = 2'd0,
        END_TIMER    = 2'd1,
        END_FULL     = 2'd2,
        END_FULL_ALT = 2'd3
    } stop_src_e;

endpackage

// File: rtl/trace_cap_mem.sv
module trace_cap_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            store[wr_addr_i] <= wr_data_i;
        end
        if (rd_en_i) begin
            rd_q <= store[rd_addr_i];
        end
    end

    assign rd_data_o = rd_q;

endmodule

// File: rtl/trace_cap_fsm.sv
module trace_cap_fsm
    import trace_cap_pkg::*;
#(
    parameter int DEPTH   = 1024,
    parameter int TIMER_W = 16,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm_i,
    input  logic [1:0]         start_sel_i,
    input  logic [1:0]         stop_sel_i,
    input  logic               trig_start_i,
    input  logic               dut_start_i,
    input  logic               manual_start_i,
    input  logic               trig_stop_i,
    input  logic [CW-1:0]      pre_len_i,
    input  logic [TIMER_W-1:0] timer_len_i,
    output logic               wr_en_o,
    output logic [AW-1:0]      wr_addr_o,
    output cap_state_e         state_o,
    output logic [CW-1:0]      valid_o,
    output logic [CW-1:0]      trig_pos_o,
    output logic               fin_o,
    output logic [AW-1:0]      fin_addr_o,
    output logic [CW-1:0]      fin_cnt_o
);

    localparam logic [CW-1:0] PRE_MAX  = CW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam int            XW       = (CW > TIMER_W) ? CW : TIMER_W;

    cap_state_e    state_q, state_d;
    logic [AW-1:0] wr_ptr_q, wr_ptr_d;
    logic [CW-1:0] valid_q, valid_d;
    logic [CW-1:0] post_q, post_d;
    logic [CW-1:0] trig_q, trig_d;

    logic          start_hit;
    logic          stop_hit;
    logic [CW-1:0] pre_eff;
    logic [CW-1:0] valid_inc;
    logic [CW-1:0] post_cand;
    logic [XW-1:0] post_x;
    logic [XW-1:0] timer_x;

    // start source selection
    always_comb begin
        case (start_src_e'(start_sel_i))
            SRC_DUT:    start_hit = dut_start_i;
            SRC_MANUAL: start_hit = manual_start_i;
            default:    start_hit = trig_start_i;
        endcase
    end

    assign pre_eff   = (pre_len_i > PRE_MAX) ? PRE_MAX : pre_len_i;
    assign valid_inc = valid_q + 1'b1;
    assign post_cand = (state_q == CAP_RECORD) ? (post_q + 1'b1) : CW'(1);
    assign post_x    = XW'(post_cand);
    assign timer_x   = XW'(timer_len_i);

    // stop rule applied to the sample written this cycle
    always_comb begin
        case (stop_src_e'(stop_sel_i))
            END_TRIG:  stop_hit = trig_stop_i;
            END_TIMER: stop_hit = (post_x >= timer_x);
            default:   stop_hit = 1'b0;
        endcase
        if (valid_inc == FULL_CNT) begin
            stop_hit = 1'b1;
        end
    end

    // next-state and counter update
    always_comb begin
        state_d  = state_q;
        wr_ptr_d = wr_ptr_q;
        valid_d  = valid_q;
        post_d   = post_q;
        trig_d   = trig_q;
        unique case (state_q)
            CAP_IDLE, CAP_DONE: begin
                if (arm_i) begin
                    state_d  = CAP_ARMED;
                    wr_ptr_d = '0;
                    valid_d  = '0;
                    post_d   = '0;
                    trig_d   = '0;
                end
            end
            CAP_ARMED: begin
                wr_ptr_d = wr_ptr_q + 1'b1;
                if (start_hit) begin
                    trig_d  = valid_q;
                    valid_d = valid_inc;
                    post_d  = post_cand;
                    state_d = stop_hit ? CAP_DONE : CAP_RECORD;
                end else begin
                    valid_d = (valid_inc > pre_eff) ? pre_eff : valid_inc;
                end
            end
            CAP_RECORD: begin
                wr_ptr_d = wr_ptr_q + 1'b1;
                valid_d  = valid_inc;
                post_d   = post_cand;
                if (stop_hit) begin
                    state_d = CAP_DONE;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= CAP_IDLE;
            wr_ptr_q <= '0;
            valid_q  <= '0;
            post_q   <= '0;
            trig_q   <= '0;
        end else begin
            state_q  <= state_d;
            wr_ptr_q <= wr_ptr_d;
            valid_q  <= valid_d;
            post_q   <= post_d;
            trig_q   <= trig_d;
        end
    end

    // outputs
    always_comb begin
        wr_en_o = 1'b0;
        fin_o   = 1'b0;
        unique case (state_q)
            CAP_ARMED: begin
                wr_en_o = 1'b1;
                fin_o   = start_hit && stop_hit;
            end
            CAP_RECORD: begin
                wr_en_o = 1'b1;
                fin_o   = stop_hit;
            end
            default: begin
                wr_en_o = 1'b0;
                fin_o   = 1'b0;
            end
        endcase
    end

    assign wr_addr_o  = wr_ptr_q;
    assign state_o    = state_q;
    assign valid_o    = valid_q;
    assign trig_pos_o = trig_q;
    assign fin_cnt_o  = valid_inc;
    assign fin_addr_o = wr_ptr_q + AW'(1) - valid_inc[AW-1:0];

    // R6
    valid_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q <= FULL_CNT);

    // R2
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q == CAP_IDLE) || (state_q == CAP_DONE)) && arm_i)
        |=> ((state_q == CAP_ARMED) && (valid_q == '0)));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == CAP_DONE) && !arm_i) |=> (state_q == CAP_DONE));

    // R4
    trig_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_RECORD) |-> (trig_q < valid_q));

    // R3
    pre_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_ARMED) |-> (valid_q <= PRE_MAX));

endmodule

// File: rtl/trace_cap_reader.sv
module trace_cap_reader #(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fin_i,
    input  logic [AW-1:0] fin_addr_i,
    input  logic [CW-1:0] fin_cnt_i,
    input  logic          in_done_i,
    input  logic          rd_req_i,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          rd_valid_o
);

    logic [AW-1:0] ptr_q;
    logic [CW-1:0] left_q;
    logic          valid_q;

    assign rd_en_o   = rd_req_i && in_done_i && (left_q != '0);
    assign rd_addr_o = ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            left_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= rd_en_o;
            if (fin_i) begin
                ptr_q  <= fin_addr_i;
                left_q <= fin_cnt_i;
            end else if (rd_en_o) begin
                ptr_q  <= ptr_q + 1'b1;
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign rd_valid_o = valid_q;

    // R8
    drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_done_i && rd_req_i && (left_q != '0))
        |=> (left_q == $past(left_q) - 1'b1));

    // R8
    read_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(in_done_i));

endmodule

// File: rtl/trace_cap_dutctl.sv
module trace_cap_dutctl (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic step_i,
    input  logic rst_req_i,
    output logic clk_en_o,
    output logic rst_o
);

    logic en_q;
    logic rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            rst_q <= 1'b1;
        end else begin
            en_q  <= run_i || step_i;
            rst_q <= rst_req_i;
        end
    end

    assign clk_en_o = en_q;
    assign rst_o    = rst_q;

    // R9
    step_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> clk_en_o);

    // R9
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !step_i) |=> !clk_en_o);

    // R10
    dut_reset_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_i |=> rst_o);

endmodule

// File: rtl/trace_capture.sv
module trace_capture
    import trace_cap_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 1024,
    parameter int TIMER_W = 16,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  probe_i,
    input  logic               arm_i,
    input  logic [1:0]         start_sel_i,
    input  logic [1:0]         stop_sel_i,
    input  logic               trig_start_i,
    input  logic               dut_start_i,
    input  logic               manual_start_i,
    input  logic               trig_stop_i,
    input  logic [CW-1:0]      pre_len_i,
    input  logic [TIMER_W-1:0] timer_len_i,
    input  logic               rd_req_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               rd_valid_o,
    output logic [1:0]         state_o,
    output logic [CW-1:0]      valid_cnt_o,
    output logic [CW-1:0]      trig_pos_o,
    input  logic               mon_en_i,
    output logic [DATA_W-1:0]  mon_data_o,
    input  logic               dut_run_i,
    input  logic               dut_step_i,
    input  logic               dut_rst_req_i,
    output logic               dut_clk_en_o,
    output logic               dut_rst_o
);

    cap_state_e        seq_state;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic              fin;
    logic [AW-1:0]     fin_addr;
    logic [CW-1:0]     fin_cnt;
    logic              rd_en;
    logic [AW-1:0]     rd_addr;
    logic [DATA_W-1:0] mon_q;

    trace_cap_fsm #(
        .DEPTH   (DEPTH),
        .TIMER_W (TIMER_W)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .arm_i          (arm_i),
        .start_sel_i    (start_sel_i),
        .stop_sel_i     (stop_sel_i),
        .trig_start_i   (trig_start_i),
        .dut_start_i    (dut_start_i),
        .manual_start_i (manual_start_i),
        .trig_stop_i    (trig_stop_i),
        .pre_len_i      (pre_len_i),
        .timer_len_i    (timer_len_i),
        .wr_en_o        (wr_en),
        .wr_addr_o      (wr_addr),
        .state_o        (seq_state),
        .valid_o        (valid_cnt_o),
        .trig_pos_o     (trig_pos_o),
        .fin_o          (fin),
        .fin_addr_o     (fin_addr),
        .fin_cnt_o      (fin_cnt)
    );

    trace_cap_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_mem (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (probe_i),
        .rd_en_i   (rd_en),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data_o)
    );

    trace_cap_reader #(
        .DEPTH (DEPTH)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .fin_i      (fin),
        .fin_addr_i (fin_addr),
        .fin_cnt_i  (fin_cnt),
        .in_done_i  (seq_state == CAP_DONE),
        .rd_req_i   (rd_req_i),
        .rd_en_o    (rd_en),
        .rd_addr_o  (rd_addr),
        .rd_valid_o (rd_valid_o)
    );

    trace_cap_dutctl u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (dut_run_i),
        .step_i    (dut_step_i),
        .rst_req_i (dut_rst_req_i),
        .clk_en_o  (dut_clk_en_o),
        .rst_o     (dut_rst_o)
    );

    // live monitor path, independent of the recording memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '0;
        end else if (mon_en_i) begin
            mon_q <= probe_i;
        end
    end

    assign mon_data_o = mon_q;
    assign state_o    = seq_state;

    // R11
    mon_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en_i |=> $stable(mon_data_o));

endmodule

// File: tb/trace_capture_test.sv
module trace_capture_test;

    localparam int DW = 32;
    localparam int DP = 16;
    localparam int TW = 8;
    localparam int CW = $clog2(DP) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] probe = '0;
    logic          arm = 1'b0;
    logic [1:0]    start_sel = 2'd0;
    logic [1:0]    stop_sel = 2'd0;
    logic          trig_start = 1'b0;
    logic          dut_start = 1'b0;
    logic          manual = 1'b0;
    logic          trig_stop = 1'b0;
    logic [CW-1:0] pre_len = '0;
    logic [TW-1:0] timer_len = '0;
    logic          rd_req = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic [1:0]    state;
    logic [CW-1:0] valid_cnt;
    logic [CW-1:0] trig_pos;
    logic          mon_en = 1'b0;
    logic [DW-1:0] mon_data;
    logic          run = 1'b0;
    logic          stp = 1'b0;
    logic          rst_req = 1'b0;
    logic          clk_en;
    logic          dut_rst;

    always #10 clk = ~clk;

    trace_capture #(
        .DATA_W  (DW),
        .DEPTH   (DP),
        .TIMER_W (TW)
    ) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .probe_i        (probe),
        .arm_i          (arm),
        .start_sel_i    (start_sel),
        .stop_sel_i     (stop_sel),
        .trig_start_i   (trig_start),
        .dut_start_i    (dut_start),
        .manual_start_i (manual),
        .trig_stop_i    (trig_stop),
        .pre_len_i      (pre_len),
        .timer_len_i    (timer_len),
        .rd_req_i       (rd_req),
        .rd_data_o      (rd_data),
        .rd_valid_o     (rd_valid),
        .state_o        (state),
        .valid_cnt_o    (valid_cnt),
        .trig_pos_o     (trig_pos),
        .mon_en_i       (mon_en),
        .mon_data_o     (mon_data),
        .dut_run_i      (run),
        .dut_step_i     (stp),
        .dut_rst_req_i  (rst_req),
        .dut_clk_en_o   (clk_en),
        .dut_rst_o      (dut_rst)
    );

    int checks = 0;
    int fails = 0;
    int n = 0;
    int armed_at = 0;
    int p = 0;
    bit finished = 1'b0;
    logic [31:0] expq[$];
    logic [31:0] mon_exp;
    logic [31:0] held;

    function automatic logic [31:0] pat(int k);
        return (32'(k) * 32'h9E37_79B1) ^ 32'h0F0F_1234;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        n++;
        probe = pat(n);
    endtask

    task automatic do_arm();
        step();
        arm = 1'b1;
        step();
        arm = 1'b0;
        armed_at = n;
    endtask

    task automatic push_window(int first, int cnt);
        for (int i = 0; i < cnt; i++) begin
            expq.push_back(pat(first + i));
        end
    endtask

    task automatic drain(int cnt);
        for (int i = 0; i < cnt + 2; i++) begin
            step();
            rd_req = 1'b1;
        end
        step();
        rd_req = 1'b0;
        step();
        step();
        chk("R8 queue empty after drain", 32'(expq.size()), 32'd0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (expq.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R8 unexpected read actual=%0h expected=none", rd_data);
            end else begin
                mon_exp = expq.pop_front();
                chk("R8 readout order", rd_data, mon_exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 state", 32'(state), 32'd0);
        chk("R1 valid", 32'(valid_cnt), 32'd0);
        chk("R1 dut_rst", 32'(dut_rst), 32'd1);
        chk("R1 clk_en", 32'(clk_en), 32'd0);
        chk("R1 rd_valid", 32'(rd_valid), 32'd0);
        rst_n = 1'b1;

        // R3 R4 R5 timer stop, trigger start, ignored arm and stop pulse
        pre_len = 5'd4; timer_len = 8'd5; start_sel = 2'd0; stop_sel = 2'd1;
        do_arm();
        chk("R2 armed", 32'(state), 32'd1);
        chk("R2 valid cleared", 32'(valid_cnt), 32'd0);
        repeat (10) step();
        trig_start = 1'b1; p = n;
        step();
        trig_start = 1'b0;
        trig_stop = 1'b1; arm = 1'b1;
        step();
        trig_stop = 1'b0; arm = 1'b0;
        chk("R2 arm ignored in recording", 32'(state), 32'd2);
        repeat (6) step();
        chk("R5 timer done", 32'(state), 32'd3);
        chk("R3 R5 count", 32'(valid_cnt), 32'd9);
        chk("R4 trig pos", 32'(trig_pos), 32'd4);
        push_window(p - 4, 9);
        drain(9);
        chk("R7 done holds", 32'(state), 32'd3);

        // R3 short pretrigger, manual start, stop trigger
        pre_len = 5'd8; start_sel = 2'd2; stop_sel = 2'd0;
        do_arm();
        repeat (3) step();
        manual = 1'b1; p = n;
        step();
        manual = 1'b0;
        step();
        trig_stop = 1'b1;
        step();
        trig_stop = 1'b0;
        step();
        chk("R5 stop trigger done", 32'(state), 32'd3);
        chk("R3 partial pretrigger count", 32'(valid_cnt), 32'd6);
        chk("R3 partial trig pos", 32'(trig_pos), 32'd3);
        push_window(p - 3, 6);
        drain(6);

        // R4 unselected starts ignored, R6 full stop with wrap
        pre_len = 5'd5; start_sel = 2'd1; stop_sel = 2'd2;
        do_arm();
        step(); trig_start = 1'b1;
        step(); trig_start = 1'b0; manual = 1'b1;
        step(); manual = 1'b0; trig_stop = 1'b1;
        step(); trig_stop = 1'b0;
        chk("R4 unselected start ignored", 32'(state), 32'd1);
        repeat (3) step();
        dut_start = 1'b1; p = n;
        step();
        dut_start = 1'b0;
        repeat (15) step();
        chk("R6 full done", 32'(state), 32'd3);
        chk("R6 full count", 32'(valid_cnt), 32'd16);
        chk("R4 design start trig pos", 32'(trig_pos), 32'd5);
        push_window(p - 5, 16);
        drain(16);

        // R5 start and stop trigger in the same cycle
        pre_len = 5'd0; start_sel = 2'd0; stop_sel = 2'd0;
        do_arm();
        repeat (2) step();
        trig_start = 1'b1; trig_stop = 1'b1; p = n;
        step();
        trig_start = 1'b0; trig_stop = 1'b0;
        step();
        chk("R5 same-cycle stop state", 32'(state), 32'd3);
        chk("R5 same-cycle count", 32'(valid_cnt), 32'd1);
        chk("R5 same-cycle trig pos", 32'(trig_pos), 32'd0);
        push_window(p, 1);
        drain(1);

        // R6 start with full pretrigger fills memory in the start cycle
        pre_len = 5'd20; timer_len = 8'd200; stop_sel = 2'd1;
        do_arm();
        repeat (20) step();
        trig_start = 1'b1; p = n;
        step();
        trig_start = 1'b0;
        step();
        chk("R6 start-full state", 32'(state), 32'd3);
        chk("R6 start-full count", 32'(valid_cnt), 32'd16);
        chk("R3 clamped pretrigger", 32'(trig_pos), 32'd15);
        push_window(p - 15, 16);
        drain(16);

        // R9 clock enable control
        run = 1'b1; step();
        chk("R9 run enables", 32'(clk_en), 32'd1);
        run = 1'b0; step();
        chk("R9 halt", 32'(clk_en), 32'd0);
        stp = 1'b1; step(); stp = 1'b0;
        chk("R9 step enable", 32'(clk_en), 32'd1);
        step();
        chk("R9 single step only", 32'(clk_en), 32'd0);

        // R10 design reset
        rst_req = 1'b1; step();
        chk("R10 reset asserted", 32'(dut_rst), 32'd1);
        rst_req = 1'b0; step();
        chk("R10 reset released", 32'(dut_rst), 32'd0);

        // R11 live monitor
        mon_en = 1'b1;
        step(); step();
        chk("R11 monitor follows", mon_data, pat(n - 1));
        held = pat(n - 1);
        mon_en = 1'b0;
        step(); step();
        chk("R11 monitor holds", mon_data, held);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule